// File: doc/BRIEF.md
# Multi-Phase Instruction Sequencer

This block is the control unit of a 16-bit load-store processor. Instructions are one or two words long. A flag bit in the first word tells the sequencer to spend an extra phase fetching a second word, which becomes the constant operand. Instructions carry no inline constant. The sequencer holds the program counter, the instruction word, the constant word, a 2-bit phase register and an interrupt-in-service flag.

It fetches over a simple memory port. The port is zero-wait: the read data for `mem_addr` is valid in the same cycle and is captured at the edge that ends the phase. The memory port has no valid/ready handshake. The only back-pressure is `io_hold`, which an external I/O controller raises to take the memory for direct access. While it is high the sequencer freezes and masks its write strobes.

The block drives the datapath controls: register indices, operand select, ALU function, writeback source and write strobes. It computes branch targets and data addresses itself from `ra_data`, the value of register Ra. Every branch writes its return address. Addresses are word addresses.

Top module: `multiphase_seq`

## Requirements
- R1: While `rst_n` is low and after its release, the PC is 0, `phase_o` is 0 (fetch), `in_service` is 0, and `reg_we` and `mem_we` are 0 in the fetch phase.
- R2: In phase 0 `mem_addr` equals the PC. The edge that ends the phase captures `mem_rdata` as the instruction and increments the PC. The next phase is 1 if instruction bit 10 is 1, and 2 otherwise. Field positions: Ra is bits 8:6, Rb is bits 5:3, Rc is bits 2:0.
- R3: In phase 1 `mem_addr` equals the PC. The closing edge loads `mem_rdata` into the constant register (`const_o`), increments the PC and moves to phase 2.
- R4: When bit 9 is 0 the instruction is an ALU operation. In phase 2: `alu_fn` = bits 15:11, `bsel` = bit 10, `reg_we` = 1, `wr_idx` = Rc, `wb_sel` = 1 (ALU), `rb_idx` = Rb, and the PC is unchanged. Phase 2 then returns to phase 0.
- R5: When bit 9 is 1, bits 13:11 select the operation. Code 0 is branch-if-Ra-zero and code 1 is branch-if-Ra-nonzero. In phase 2 Rc is written with the PC (the next instruction's address) through `wb_sel` = 0. If the branch is taken, the PC becomes PC + constant.
- R6: Code 2 jumps to Ra + constant. Code 3 is a one-word jump to Ra. Both write the PC into Rc. Code 3 with Ra field = 6 clears `in_service`.
- R7: Code 4 reads memory at Ra + constant. Code 5 reads memory at PC + constant. For both, phase 2 drives that address on `mem_addr` and writes Rc with `wb_sel` = 2 (memory).
- R8: Code 6 stores. In phase 2 `mem_addr` = Ra + constant, `mem_we` = 1, `rb_idx` = Rc and `reg_we` = 0. `mem_we` is 0 in every other case.
- R9: At the end of phase 2, if `irq_req` = 1 and `in_service` = 0, the sequencer enters phase 3. In phase 3 it writes the PC to register 6 (`wr_idx` = 6, `wb_sel` = 0, `reg_we` = 1). The next edge sets the PC to the vector (default 8), sets `in_service` and returns to phase 0. A request in any other phase, or while `in_service` = 1, does not divert the flow.
- R10: While `io_hold` = 1, the phase, PC, instruction, constant and flag keep their values, and `reg_we` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_hold | input | 1 | Freeze request from the I/O controller |
| irq_req | input | 1 | Interrupt request level |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_rdata | input | 16 | Read data for `mem_addr`, valid in the same cycle |
| mem_we | output | 1 | Memory write strobe |
| ra_data | input | 16 | Current value of register Ra |
| alu_fn | output | 5 | ALU function |
| bsel | output | 1 | ALU B operand: 1 = constant, 0 = register |
| ra_idx | output | 3 | Register file channel A index |
| rb_idx | output | 3 | Register file channel B index |
| wr_idx | output | 3 | Register file write index |
| wb_sel | output | 2 | Writeback source: 0 PC, 1 ALU, 2 memory |
| reg_we | output | 1 | Register write strobe |
| const_o | output | 16 | Constant register |
| pc_o | output | 16 | Program counter, also the return address |
| phase_o | output | 2 | Current phase |
| in_service | output | 1 | Interrupt-in-service flag |

## Verification
The hardest case to reach is the interrupt boundary. Ending the handler through a jump on register 6 with the request still high must cause an immediate second entry, while an earlier request during the handler must be ignored. The stimulus holds `irq_req` high for the whole run and steps a routine at the vector. The routine ends in the register-6 jump, and the bench observes that the first request does not split a fetch, that the request during the handler is ignored, and that the flow re-enters right after the flag clears. A second hard case is a freeze during the execute phase. The bench raises `io_hold` while a write strobe is due and checks that the strobe is masked and then released with the PC held.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_CONST = 2'd1,
    PH_EXEC  = 2'd2,
    PH_TRAP  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    WB_PC   = 2'd0,
    WB_ALU  = 2'd1,
    WB_MEM  = 2'd2,
    WB_NONE = 2'd3
  } wb_t;

  localparam logic [2:0] OP_BZ   = 3'd0;
  localparam logic [2:0] OP_BNZ  = 3'd1;
  localparam logic [2:0] OP_JOFS = 3'd2;
  localparam logic [2:0] OP_JREG = 3'd3;
  localparam logic [2:0] OP_LDA  = 3'd4;
  localparam logic [2:0] OP_LDP  = 3'd5;
  localparam logic [2:0] OP_STA  = 3'd6;

  typedef struct packed {
    logic is_alu;
    logic is_bz;
    logic is_bnz;
    logic is_jofs;
    logic is_jreg;
    logic is_lda;
    logic is_ldp;
    logic is_sta;
    logic wr_reg;
    wb_t  wb;
  } dec_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic       grp,
  input  logic [2:0] code,
  output dec_t       d
);
  logic [7:0] hit;

  for (genvar i = 0; i < 8; i++) begin : g_hit
    assign hit[i] = grp && (code == 3'(i));
  end

  always_comb begin
    d.is_alu  = !grp;
    d.is_bz   = hit[OP_BZ];
    d.is_bnz  = hit[OP_BNZ];
    d.is_jofs = hit[OP_JOFS];
    d.is_jreg = hit[OP_JREG];
    d.is_lda  = hit[OP_LDA];
    d.is_ldp  = hit[OP_LDP];
    d.is_sta  = hit[OP_STA];
    d.wr_reg  = !grp || !(hit[OP_STA] || hit[7]);
    if (!grp)                    d.wb = WB_ALU;
    else if (d.is_lda || d.is_ldp) d.wb = WB_MEM;
    else if (d.wr_reg)           d.wb = WB_PC;
    else                         d.wb = WB_NONE;
  end
endmodule

// File: rtl/seq_target.sv
module seq_target
  import seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  dec_t          d,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] konst,
  input  logic [DW-1:0] ra_data,
  output logic [DW-1:0] next_pc,
  output logic [DW-1:0] data_addr
);
  logic [DW-1:0] ra_plus_k;
  logic [DW-1:0] pc_plus_k;
  logic          ra_zero;

  assign ra_plus_k = ra_data + konst;
  assign pc_plus_k = pc + konst;
  assign ra_zero   = (ra_data == '0);

  always_comb begin
    next_pc = pc;
    if ((d.is_bz && ra_zero) || (d.is_bnz && !ra_zero)) next_pc = pc_plus_k;
    else if (d.is_jofs)                                  next_pc = ra_plus_k;
    else if (d.is_jreg)                                  next_pc = ra_data;
  end

  assign data_addr = d.is_ldp ? pc_plus_k : ra_plus_k;
endmodule

// File: rtl/multiphase_seq.sv
module multiphase_seq
  import seq_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            RIW      = 3,
  parameter int            TRAP_REG = 6,
  parameter logic [DW-1:0] VECTOR   = 'h8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_hold,
  input  logic           irq_req,
  output logic [DW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_we,
  input  logic [DW-1:0]  ra_data,
  output logic [DW-3*RIW-3:0] alu_fn,
  output logic           bsel,
  output logic [RIW-1:0] ra_idx,
  output logic [RIW-1:0] rb_idx,
  output logic [RIW-1:0] wr_idx,
  output logic [1:0]     wb_sel,
  output logic           reg_we,
  output logic [DW-1:0]  const_o,
  output logic [DW-1:0]  pc_o,
  output logic [1:0]     phase_o,
  output logic           in_service
);
  localparam int RC_LO   = 0;
  localparam int RB_LO   = RIW;
  localparam int RA_LO   = 2 * RIW;
  localparam int GRP_BIT = 3 * RIW;
  localparam int CF_BIT  = 3 * RIW + 1;
  localparam int FN_LO   = 3 * RIW + 2;
  localparam logic [RIW-1:0] TRAP_IDX = RIW'(TRAP_REG);

  phase_t        ph;
  logic [DW-1:0] pc, ir, kreg;
  logic          iflag;
  dec_t          d;
  logic [DW-1:0] pc_exec, daddr;
  logic          take_irq, ends_isr, in_exec, in_trap;

  seq_decode u_dec (
    .grp  (ir[GRP_BIT]),
    .code (ir[FN_LO +: 3]),
    .d    (d)
  );

  seq_target #(.DW(DW)) u_tgt (
    .d         (d),
    .pc        (pc),
    .konst     (kreg),
    .ra_data   (ra_data),
    .next_pc   (pc_exec),
    .data_addr (daddr)
  );

  assign take_irq = irq_req && !iflag;
  assign ends_isr = d.is_jreg && (ir[RA_LO +: RIW] == TRAP_IDX);
  assign in_exec  = (ph == PH_EXEC);
  assign in_trap  = (ph == PH_TRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_FETCH;
      pc    <= '0;
      ir    <= '0;
      kreg  <= '0;
      iflag <= 1'b0;
    end else if (!io_hold) begin
      unique case (ph)
        PH_FETCH: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          ph <= mem_rdata[CF_BIT] ? PH_CONST : PH_EXEC;
        end
        PH_CONST: begin
          kreg <= mem_rdata;
          pc   <= pc + 1'b1;
          ph   <= PH_EXEC;
        end
        PH_EXEC: begin
          pc <= pc_exec;
          if (ends_isr) iflag <= 1'b0;
          ph <= take_irq ? PH_TRAP : PH_FETCH;
        end
        PH_TRAP: begin
          pc    <= VECTOR;
          iflag <= 1'b1;
          ph    <= PH_FETCH;
        end
        default: ph <= PH_FETCH;
      endcase
    end
  end

  assign mem_addr   = (in_exec && (d.is_lda || d.is_ldp || d.is_sta)) ? daddr : pc;
  assign mem_we     = in_exec && d.is_sta && !io_hold;
  assign reg_we     = !io_hold && ((in_exec && d.wr_reg) || in_trap);
  assign wr_idx     = in_trap ? TRAP_IDX : ir[RC_LO +: RIW];
  assign wb_sel     = in_trap ? WB_PC : d.wb;
  assign ra_idx     = ir[RA_LO +: RIW];
  assign rb_idx     = d.is_sta ? ir[RC_LO +: RIW] : ir[RB_LO +: RIW];
  assign bsel       = ir[CF_BIT];
  assign alu_fn     = ir[DW-1:FN_LO];
  assign const_o    = kreg;
  assign pc_o       = pc;
  assign phase_o    = ph;
  assign in_service = iflag;
endmodule

// File: rtl/multiphase_seq_chk.sv
module multiphase_seq_chk #(
  parameter int            DW       = 16,
  parameter int            RIW      = 3,
  parameter int            TRAP_REG = 6,
  parameter logic [DW-1:0] VECTOR   = 'h8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           io_hold,
  input logic           mem_we,
  input logic           reg_we,
  input logic [RIW-1:0] wr_idx,
  input logic [1:0]     wb_sel,
  input logic [DW-1:0]  pc_o,
  input logic [1:0]     phase_o,
  input logic           in_service
);
  p_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && !io_hold) |=> (phase_o == 2'd1 || phase_o == 2'd2));

  p_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1 && !io_hold) |=> (phase_o == 2'd2 && pc_o == $past(pc_o) + 1'b1));

  p_store_only_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase_o == 2'd2 && !io_hold));

  p_trap_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3 && !io_hold) |-> (reg_we && wr_idx == RIW'(TRAP_REG) && wb_sel == 2'd0));

  p_trap_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3 && !io_hold) |=> (pc_o == VECTOR && in_service && phase_o == 2'd0));

  p_no_nest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2 && in_service && !io_hold) |=> (phase_o == 2'd0));

  p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_service) |-> ($past(phase_o) == 2'd3));

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_hold |=> (pc_o == $past(pc_o) && phase_o == $past(phase_o) && in_service == $past(in_service)));

  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_hold |-> (!reg_we && !mem_we));
endmodule

bind multiphase_seq multiphase_seq_chk #(
  .DW(DW), .RIW(RIW), .TRAP_REG(TRAP_REG), .VECTOR(VECTOR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_hold    (io_hold),
  .mem_we     (mem_we),
  .reg_we     (reg_we),
  .wr_idx     (wr_idx),
  .wb_sel     (wb_sel),
  .pc_o       (pc_o),
  .phase_o    (phase_o),
  .in_service (in_service)
);

// File: tb/sim_multiphase_seq.sv
module sim_multiphase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_hold = 1'b0;
  logic        irq_req = 1'b0;
  logic [15:0] mem_addr, mem_rdata, ra_data = '0;
  logic        mem_we, bsel, reg_we, in_service;
  logic [4:0]  alu_fn;
  logic [2:0]  ra_idx, rb_idx, wr_idx;
  logic [1:0]  wb_sel, phase_o;
  logic [15:0] const_o, pc_o;
  logic [15:0] mem [0:255];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr[7:0]];

  multiphase_seq u0 (
    .clk(clk), .rst_n(rst_n), .io_hold(io_hold), .irq_req(irq_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .ra_data(ra_data), .alu_fn(alu_fn), .bsel(bsel), .ra_idx(ra_idx),
    .rb_idx(rb_idx), .wr_idx(wr_idx), .wb_sel(wb_sel), .reg_we(reg_we),
    .const_o(const_o), .pc_o(pc_o), .phase_o(phase_o), .in_service(in_service)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: got cycle %0d exp below %0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; io_hold = 1'b0; irq_req = 1'b0; ra_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  function automatic logic [15:0] alu_w(logic [4:0] fn, logic c, logic [2:0] a, logic [2:0] b, logic [2:0] r);
    return {fn, c, 1'b0, a, b, r};
  endfunction

  function automatic logic [15:0] spc_w(logic [2:0] code, logic c, logic [2:0] a, logic [2:0] b, logic [2:0] r);
    return {2'b00, code, c, 1'b1, a, b, r};
  endfunction

  task automatic t_reset();
    clear_mem();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "pc in reset", pc_o, 0);
    chk("R1", "phase in reset", phase_o, 0);
    do_reset();
    chk("R1", "pc after reset", pc_o, 0);
    chk("R1", "phase after reset", phase_o, 0);
    chk("R1", "flag after reset", in_service, 0);
    chk("R1", "no writes in fetch", {reg_we, mem_we}, 0);
  endtask

  task automatic t_alu_rr();
    clear_mem();
    mem[0] = alu_w(5'b10110, 1'b0, 3'd1, 3'd2, 3'd3);
    do_reset();
    chk("R2", "fetch addr", mem_addr, 0);
    tick();
    chk("R2", "skip const phase", phase_o, 2);
    chk("R2", "pc incremented", pc_o, 1);
    chk("R4", "alu_fn", alu_fn, 5'b10110);
    chk("R4", "bsel reg", bsel, 0);
    chk("R4", "ra_idx", ra_idx, 1);
    chk("R4", "rb_idx", rb_idx, 2);
    chk("R4", "wr_idx", wr_idx, 3);
    chk("R4", "reg_we", reg_we, 1);
    chk("R4", "wb alu", wb_sel, 1);
    chk("R4", "no mem write", mem_we, 0);
    tick();
    chk("R4", "back to fetch", phase_o, 0);
    chk("R4", "pc unchanged", pc_o, 1);
  endtask

  task automatic t_alu_const();
    clear_mem();
    mem[0] = alu_w(5'b00001, 1'b1, 3'd4, 3'd0, 3'd5);
    mem[1] = 16'h1234;
    do_reset();
    tick();
    chk("R2", "const phase entered", phase_o, 1);
    chk("R3", "const fetch addr", mem_addr, 1);
    tick();
    chk("R3", "exec after const", phase_o, 2);
    chk("R3", "pc after const", pc_o, 2);
    chk("R3", "constant loaded", const_o, 16'h1234);
    chk("R4", "bsel const", bsel, 1);
    chk("R4", "alu_fn const", alu_fn, 5'b00001);
    chk("R4", "wr_idx const", wr_idx, 5);
  endtask

  task automatic t_branch(input logic [2:0] code, input logic [15:0] ra, input logic [15:0] ofs, input logic [15:0] exp_pc, input string tag);
    clear_mem();
    mem[0] = spc_w(code, 1'b1, 3'd2, 3'd0, 3'd1);
    mem[1] = ofs;
    do_reset();
    ra_data = ra;
    tick(); tick();
    chk("R5", {tag, " link write"}, {reg_we, wr_idx, wb_sel}, {1'b1, 3'd1, 2'd0});
    chk("R5", {tag, " return addr"}, pc_o, 2);
    tick();
    chk("R5", {tag, " new pc"}, pc_o, exp_pc);
  endtask

  task automatic t_jumps();
    clear_mem();
    mem[0] = spc_w(3'd2, 1'b1, 3'd3, 3'd0, 3'd2);
    mem[1] = 16'h0100;
    do_reset();
    ra_data = 16'h0020;
    tick(); tick();
    chk("R6", "jofs link", {reg_we, wr_idx, wb_sel, pc_o}, {1'b1, 3'd2, 2'd0, 16'd2});
    tick();
    chk("R6", "jofs target", pc_o, 16'h0120);
    clear_mem();
    mem[0] = spc_w(3'd3, 1'b0, 3'd1, 3'd0, 3'd4);
    do_reset();
    ra_data = 16'h0040;
    tick();
    chk("R6", "jreg one word", phase_o, 2);
    chk("R6", "jreg link", {reg_we, wr_idx, pc_o}, {1'b1, 3'd4, 16'd1});
    tick();
    chk("R6", "jreg target", pc_o, 16'h0040);
  endtask

  task automatic t_loads();
    clear_mem();
    mem[0] = spc_w(3'd4, 1'b1, 3'd1, 3'd0, 3'd3);
    mem[1] = 16'h0005;
    do_reset();
    ra_data = 16'h0010;
    tick(); tick();
    chk("R7", "lda addr", mem_addr, 16'h0015);
    chk("R7", "lda write", {reg_we, wr_idx, wb_sel}, {1'b1, 3'd3, 2'd2});
    tick();
    chk("R7", "lda pc after", pc_o, 2);
    clear_mem();
    mem[0] = spc_w(3'd5, 1'b1, 3'd0, 3'd0, 3'd3);
    mem[1] = 16'h0007;
    do_reset();
    tick(); tick();
    chk("R7", "ldp addr", mem_addr, 16'h0009);
    chk("R7", "ldp wb mem", wb_sel, 2);
  endtask

  task automatic t_store();
    clear_mem();
    mem[0] = spc_w(3'd6, 1'b1, 3'd1, 3'd2, 3'd5);
    mem[1] = 16'h0003;
    do_reset();
    ra_data = 16'h0020;
    chk("R8", "no write in fetch", mem_we, 0);
    tick();
    chk("R8", "no write in const", mem_we, 0);
    tick();
    chk("R8", "store strobe", mem_we, 1);
    chk("R8", "store addr", mem_addr, 16'h0023);
    chk("R8", "store data reg", rb_idx, 5);
    chk("R8", "no reg write", reg_we, 0);
    tick();
    chk("R8", "strobe ends", mem_we, 0);
  endtask

  task automatic t_irq();
    clear_mem();
    mem[0] = alu_w(5'b00000, 1'b0, 3'd1, 3'd2, 3'd3);
    mem[1] = alu_w(5'b00000, 1'b0, 3'd1, 3'd2, 3'd3);
    mem[8] = alu_w(5'b00000, 1'b0, 3'd1, 3'd2, 3'd3);
    mem[9] = spc_w(3'd3, 1'b0, 3'd6, 3'd0, 3'd7);
    do_reset();
    irq_req = 1'b1;
    tick();
    chk("R9", "fetch not split", phase_o, 2);
    tick();
    chk("R9", "trap phase", phase_o, 3);
    chk("R9", "save to r6", {reg_we, wr_idx, wb_sel}, {1'b1, 3'd6, 2'd0});
    chk("R9", "return addr", pc_o, 1);
    chk("R9", "flag still clear", in_service, 0);
    tick();
    chk("R9", "vector", pc_o, 16'h0008);
    chk("R9", "flag set", in_service, 1);
    tick(); tick();
    chk("R9", "no nesting", phase_o, 0);
    chk("R9", "handler continues", pc_o, 9);
    ra_data = 16'h0001;
    tick(); tick();
    chk("R6", "isr end flag", in_service, 0);
    chk("R6", "isr return", pc_o, 1);
    tick(); tick();
    chk("R9", "re-entry after clear", phase_o, 3);
    irq_req = 1'b0;
  endtask

  task automatic t_hold();
    clear_mem();
    mem[0] = alu_w(5'b00011, 1'b1, 3'd4, 3'd0, 3'd5);
    mem[1] = 16'hBEEF;
    do_reset();
    io_hold = 1'b1;
    repeat (3) tick();
    chk("R10", "fetch frozen", {phase_o, pc_o}, {2'd0, 16'd0});
    io_hold = 1'b0;
    tick();
    io_hold = 1'b1;
    tick();
    chk("R10", "const frozen", {phase_o, pc_o, const_o}, {2'd1, 16'd1, 16'h0000});
    io_hold = 1'b0;
    tick();
    chk("R10", "const loaded after", const_o, 16'hBEEF);
    io_hold = 1'b1;
    #1;
    chk("R10", "write masked", reg_we, 0);
    tick();
    chk("R10", "exec frozen", {phase_o, pc_o}, {2'd2, 16'd2});
    io_hold = 1'b0;
    #1;
    chk("R10", "write released", reg_we, 1);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_alu_rr();
    t_alu_const();
    t_branch(3'd0, 16'h0000, 16'h0010, 16'h0012, "bz taken");
    t_branch(3'd0, 16'h0003, 16'h0010, 16'h0002, "bz not taken");
    t_branch(3'd1, 16'h0003, 16'hFFFE, 16'h0000, "bnz taken");
    t_branch(3'd1, 16'h0000, 16'hFFFE, 16'h0002, "bnz not taken");
    t_jumps();
    t_loads();
    t_store();
    t_irq();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule